// File: doc/BRIEF.md
# Interrupt Status and Multicast Filter Register Bank

This block is a small control and status register bank for a network controller. It keeps two interrupt sources, each made of a sticky status bit and an enable bit. One source records every change of level on a PHY-presence input. The other records the end of each management frame that an internal engine produces. A summary interrupt output is raised while any enabled status bit is set.

The bank also stores a 48-bit logical address filter as three 16-bit words. The words can be filled in two ways. An initialization engine can load all 48 bits in one cycle. The host can also write each word, but only while the controller is stopped or suspended. A host filter write outside those modes is dropped, and a one-cycle flag reports the drop.

Status bits clear only through a host write of 1. Hard reset clears the status and enable bits but leaves the filter alone. Soft reset and the STOP mode leave every bit of the bank unchanged.

Top module: `nic_irq_filter_regs`

## Requirements
- R1: A change of level on `phy_det`, rising or falling, sets the PHY-transition status (control register bit 0) at the second rising clock edge after the change. No event comes from reset itself while `phy_det` holds a steady level.
- R2: The control register is at address 0. Bit 0 is the PHY-transition status, bit 1 its enable, bit 2 the management-done status and bit 3 its enable. Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged. Enable bits take the written value on every write to address 0.
- R3: If a hardware set event and a host write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R4: Hard reset (`hrst`, synchronous) clears both status bits and both enable bits. Pulsing `srst` or holding `stop_mode` changes no bit of the bank.
- R5: `irq` is high exactly while (bit0 AND bit1) OR (bit2 AND bit3) holds in the control register.
- R6: A one-cycle `mgmt_done` pulse sets the management-done status (bit 2) at the next rising edge.
- R7: Filter words 0, 1 and 2 are at addresses 1, 2 and 3 and sit in read bits 15:0. Read bits 31:16 of those addresses, and read bits 31:4 of address 0, are 0. A host write to a filter word takes effect only while `stop_mode` or `susp_mode` is high.
- R8: A host filter write made while both `stop_mode` and `susp_mode` are low leaves the word unchanged. `wr_ignored` is then high for exactly the one cycle after that edge.
- R9: A pulse on `init_load` loads `init_filter[15:0]` into word 0, bits 31:16 into word 1 and bits 47:32 into word 2, in any mode.
- R10: Hard reset leaves the filter words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hrst | input | 1 | Hard reset, synchronous, active high |
| srst | input | 1 | Soft reset, has no effect on this bank |
| stop_mode | input | 1 | Controller stopped |
| susp_mode | input | 1 | Controller suspended |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| init_load | input | 1 | Bulk filter load strobe |
| init_filter | input | 48 | Bulk filter value |
| phy_det | input | 1 | PHY-presence level |
| mgmt_done | input | 1 | Management frame finished pulse |
| irq | output | 1 | Summary interrupt |
| wr_ignored | output | 1 | Dropped filter write flag |

## Verification
Writes, `mgmt_done` pulses and `init_load` take effect at the first rising edge. `wr_ignored` is valid during the cycle after that edge. A `phy_det` change passes through an input register first, so its status bit appears one edge later, at the second edge. Because reads and `irq` are combinational from the registers, the bench drives inputs on falling edges and samples on the falling edge after the edge at which each result is due. For the PHY path it also checks the intermediate falling edge, where the status must still be clear.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
   localparam int CTRL_ADDR  = 0;
   localparam int BIT_PHY_ST = 0;
   localparam int BIT_PHY_EN = 1;
   localparam int BIT_MGT_ST = 2;
   localparam int BIT_MGT_EN = 3;
   typedef enum logic {SRC_PULSE = 1'b0, SRC_LEVEL = 1'b1} src_kind_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import nic_regs_pkg::*;
#(
   parameter src_kind_e KIND = SRC_PULSE
) (
   input  logic clk,
   input  logic hrst,
   input  logic src_in,
   input  logic clr_w1,
   input  logic en_wr,
   input  logic en_val,
   output logic st,
   output logic en
);
   logic hit;

   generate
      if (KIND == SRC_LEVEL) begin : g_level
         logic smp_q, smp_prev;
         always_ff @(posedge clk) begin
            if (hrst) begin
               smp_q    <= src_in;
               smp_prev <= src_in;
            end else begin
               smp_q    <= src_in;
               smp_prev <= smp_q;
            end
         end
         assign hit = smp_q ^ smp_prev;
      end else begin : g_pulse
         assign hit = src_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (hrst) begin
         st <= 1'b0;
         en <= 1'b0;
      end else begin
         if (hit)         st <= 1'b1;
         else if (clr_w1) st <= 1'b0;
         if (en_wr)       en <= en_val;
      end
   end

   assert_set_on_event_R1: assert property (@(posedge clk) disable iff (hrst)
      hit |=> st);
   assert_set_wins_R3: assert property (@(posedge clk) disable iff (hrst)
      (hit && clr_w1) |=> st);
   assert_w1c_R2: assert property (@(posedge clk) disable iff (hrst)
      (clr_w1 && !hit) |=> !st);
   assert_hold_R2: assert property (@(posedge clk) disable iff (hrst)
      (!clr_w1 && !hit) |=> $stable(st) || st);
   assert_hard_reset_R4: assert property (@(posedge clk)
      hrst |=> (!st && !en));
endmodule

// File: rtl/lafilt_bank.sv
module lafilt_bank #(
   parameter int WORDS  = 3,
   parameter int WORD_W = 16,
   localparam int TOT_W = WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              hrst,
   input  logic [WORDS-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wdata,
   input  logic              open_ok,
   input  logic              init_load,
   input  logic [TOT_W-1:0]  init_val,
   output logic [TOT_W-1:0]  words,
   output logic              wr_drop
);
   generate
      for (genvar i = 0; i < WORDS; i++) begin : g_word
         logic [WORD_W-1:0] w_q;
         always_ff @(posedge clk) begin
            if (init_load)
               w_q <= init_val[i*WORD_W +: WORD_W];
            else if (wr_sel[i] && open_ok)
               w_q <= wdata;
         end
         assign words[i*WORD_W +: WORD_W] = w_q;

         assert_blocked_write_R8: assert property (@(posedge clk) disable iff (hrst)
            (wr_sel[i] && !open_ok && !init_load) |=> $stable(w_q));
         assert_init_load_R9: assert property (@(posedge clk) disable iff (hrst)
            init_load |=> (w_q == $past(init_val[i*WORD_W +: WORD_W])));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (hrst) wr_drop <= 1'b0;
      else      wr_drop <= (|wr_sel) && !open_ok;
   end

   assert_drop_flag_R8: assert property (@(posedge clk) disable iff (hrst)
      ((|wr_sel) && !open_ok) |=> wr_drop);
   assert_no_drop_open_R7: assert property (@(posedge clk) disable iff (hrst)
      open_ok |=> !wr_drop);
endmodule

// File: rtl/nic_irq_filter_regs.sv
module nic_irq_filter_regs
   import nic_regs_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 32,
   parameter int WORD_W  = 16,
   parameter int FWORDS  = 3,
   localparam int FILT_W = FWORDS * WORD_W
) (
   input  logic              clk,
   input  logic              hrst,
   input  logic              srst,
   input  logic              stop_mode,
   input  logic              susp_mode,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              init_load,
   input  logic [FILT_W-1:0] init_filter,
   input  logic              phy_det,
   input  logic              mgmt_done,
   output logic              irq,
   output logic              wr_ignored
);
   if (DATA_W < WORD_W) begin : g_chk_w
      $error("DATA_W must hold a filter word");
   end
   if ((1 << ADDR_W) < FWORDS + 1) begin : g_chk_a
      $error("ADDR_W too small for the register count");
   end
   if (DATA_W <= BIT_MGT_EN) begin : g_chk_c
      $error("DATA_W too small for the control register");
   end

   logic              wr_ctrl;
   logic [FWORDS-1:0] wr_sel;
   logic              phy_st, phy_en, mgt_st, mgt_en;
   logic [FILT_W-1:0] fwords;
   logic              open_ok;

   assign wr_ctrl = host_wr && (host_addr == ADDR_W'(CTRL_ADDR));
   assign open_ok = stop_mode || susp_mode;

   generate
      for (genvar i = 0; i < FWORDS; i++) begin : g_dec
         assign wr_sel[i] = host_wr && (host_addr == ADDR_W'(i + 1));
      end
   endgenerate

   irq_src_cell #(.KIND(SRC_LEVEL)) u_phy (
      .clk(clk), .hrst(hrst), .src_in(phy_det),
      .clr_w1(wr_ctrl && host_wdata[BIT_PHY_ST]),
      .en_wr(wr_ctrl), .en_val(host_wdata[BIT_PHY_EN]),
      .st(phy_st), .en(phy_en));

   irq_src_cell #(.KIND(SRC_PULSE)) u_mgt (
      .clk(clk), .hrst(hrst), .src_in(mgmt_done),
      .clr_w1(wr_ctrl && host_wdata[BIT_MGT_ST]),
      .en_wr(wr_ctrl), .en_val(host_wdata[BIT_MGT_EN]),
      .st(mgt_st), .en(mgt_en));

   lafilt_bank #(.WORDS(FWORDS), .WORD_W(WORD_W)) u_filt (
      .clk(clk), .hrst(hrst), .wr_sel(wr_sel),
      .wdata(host_wdata[WORD_W-1:0]), .open_ok(open_ok),
      .init_load(init_load), .init_val(init_filter),
      .words(fwords), .wr_drop(wr_ignored));

   assign irq = (phy_st && phy_en) || (mgt_st && mgt_en);

   always_comb begin
      host_rdata = '0;
      if (host_addr == ADDR_W'(CTRL_ADDR)) begin
         host_rdata[BIT_PHY_ST] = phy_st;
         host_rdata[BIT_PHY_EN] = phy_en;
         host_rdata[BIT_MGT_ST] = mgt_st;
         host_rdata[BIT_MGT_EN] = mgt_en;
      end
      for (int k = 0; k < FWORDS; k++) begin
         if (host_addr == ADDR_W'(k + 1))
            host_rdata[WORD_W-1:0] = fwords[k*WORD_W +: WORD_W];
      end
   end

   assert_irq_masked_R5: assert property (@(posedge clk) disable iff (hrst)
      (!phy_en && !mgt_en) |-> !irq);
   assert_soft_reset_R4: assert property (@(posedge clk) disable iff (hrst)
      (srst && !host_wr && !init_load && !mgmt_done) |=>
         ($stable(phy_en) && $stable(mgt_en) && $stable(mgt_st)));
   assert_enable_write_R2: assert property (@(posedge clk) disable iff (hrst)
      wr_ctrl |=> (phy_en == $past(host_wdata[BIT_PHY_EN]) &&
                   mgt_en == $past(host_wdata[BIT_MGT_EN])));
endmodule

// File: tb/sim_nic_irq_filter_regs.sv
module sim_nic_irq_filter_regs;
   logic        clk = 1'b0;
   logic        hrst, srst, stop_mode, susp_mode, host_wr;
   logic [1:0]  host_addr;
   logic [31:0] host_wdata, host_rdata;
   logic        init_load, phy_det, mgmt_done, irq, wr_ignored;
   logic [47:0] init_filter;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   nic_irq_filter_regs u0 (
      .clk(clk), .hrst(hrst), .srst(srst), .stop_mode(stop_mode),
      .susp_mode(susp_mode), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .init_load(init_load), .init_filter(init_filter), .phy_det(phy_det),
      .mgmt_done(mgmt_done), .irq(irq), .wr_ignored(wr_ignored));

   typedef struct packed {
      logic        wr;
      logic [1:0]  addr;
      logic [31:0] wdata;
      logic        stop;
      logic        susp;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd1, 32'hFFFF_1234, 1'b1, 1'b0, 32'h0000_1234},  // R7 stop
      '{1'b1, 2'd2, 32'h0000_ABCD, 1'b0, 1'b1, 32'h0000_ABCD},  // R7 susp
      '{1'b1, 2'd3, 32'h7777_5A5A, 1'b1, 1'b1, 32'h0000_5A5A},  // R7 both
      '{1'b1, 2'd1, 32'h0000_9999, 1'b0, 1'b0, 32'h0000_1234},  // R8 drop
      '{1'b1, 2'd0, 32'hFFFF_FFFA, 1'b0, 1'b0, 32'h0000_000A},  // R2 enables
      '{1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000},  // R2
      '{1'b1, 2'd0, 32'h0000_0002, 1'b0, 1'b0, 32'h0000_0002},  // R2
      '{1'b0, 2'd3, 32'h0000_1111, 1'b1, 1'b0, 32'h0000_5A5A}   // R7 no write
   };

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] v);
      host_addr = a;
      #1;
      v = host_rdata;
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog got hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      hrst = 1'b1; srst = 1'b0; stop_mode = 1'b0; susp_mode = 1'b0;
      host_wr = 1'b0; host_addr = '0; host_wdata = '0; init_load = 1'b0;
      init_filter = '0; phy_det = 1'b1; mgmt_done = 1'b0;
      repeat (3) @(negedge clk);
      hrst = 1'b0;
      rd(2'd0, v); chk("R4 reset ctrl", v, 32'h0);
      chk("R5 reset irq", {31'b0, irq}, 32'h0);
      repeat (3) @(negedge clk);
      rd(2'd0, v); chk("R1 no event from reset", v, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         host_wr = VEC[i].wr; host_addr = VEC[i].addr;
         host_wdata = VEC[i].wdata; stop_mode = VEC[i].stop;
         susp_mode = VEC[i].susp;
         @(negedge clk);
         host_wr = 1'b0;
         chk("R8 wr_ignored", {31'b0, wr_ignored},
             {31'b0, VEC[i].wr && VEC[i].addr != 2'd0 && !VEC[i].stop && !VEC[i].susp});
         rd(VEC[i].addr, v); chk("R7 table", v, VEC[i].exp);
      end
      stop_mode = 1'b0; susp_mode = 1'b0;
      @(negedge clk);
      chk("R8 flag one cycle", {31'b0, wr_ignored}, 32'h0);

      // R1 falling edge of phy_det, phy enable set (0x2)
      phy_det = 1'b0;
      @(negedge clk);
      rd(2'd0, v); chk("R1 not yet after one edge", v, 32'h2);
      @(negedge clk);
      rd(2'd0, v); chk("R1 set on fall", v, 32'h3);
      chk("R5 irq enabled", {31'b0, irq}, 32'h1);
      wr(2'd0, 32'h2);
      rd(2'd0, v); chk("R2 write 0 keeps status", v, 32'h3);
      wr(2'd0, 32'h3);
      rd(2'd0, v); chk("R2 write 1 clears", v, 32'h2);
      chk("R5 irq low after clear", {31'b0, irq}, 32'h0);
      @(negedge clk); phy_det = 1'b1;
      repeat (2) @(negedge clk);
      rd(2'd0, v); chk("R1 set on rise", v, 32'h3);
      wr(2'd0, 32'h1);
      rd(2'd0, v); chk("R2 clear and disable", v, 32'h0);

      // R6 mgmt pulse, enable off
      @(negedge clk); mgmt_done = 1'b1;
      @(negedge clk); mgmt_done = 1'b0;
      rd(2'd0, v); chk("R6 mgmt sets", v, 32'h4);
      chk("R5 irq masked", {31'b0, irq}, 32'h0);
      wr(2'd0, 32'h8);
      chk("R5 irq mgmt enabled", {31'b0, irq}, 32'h1);
      wr(2'd0, 32'hC);
      rd(2'd0, v); chk("R2 mgmt cleared", v, 32'h8);

      // R3 set and clear in the same cycle
      @(negedge clk);
      mgmt_done = 1'b1; host_wr = 1'b1; host_addr = 2'd0; host_wdata = 32'hC;
      @(negedge clk);
      mgmt_done = 1'b0; host_wr = 1'b0;
      rd(2'd0, v); chk("R3 set wins", v, 32'hC);

      // R4 soft reset and stop change nothing
      @(negedge clk); srst = 1'b1; stop_mode = 1'b1;
      repeat (2) @(negedge clk); srst = 1'b0;
      rd(2'd0, v); chk("R4 soft reset ctrl", v, 32'hC);
      rd(2'd2, v); chk("R4 soft reset filter", v, 32'h0000_ABCD);
      stop_mode = 1'b0;

      // R9 init load outside stop
      @(negedge clk); init_load = 1'b1; init_filter = 48'h3333_2222_1111;
      @(negedge clk); init_load = 1'b0;
      rd(2'd1, v); chk("R9 word0", v, 32'h1111);
      rd(2'd2, v); chk("R9 word1", v, 32'h2222);
      rd(2'd3, v); chk("R9 word2", v, 32'h3333);

      // R4 / R10 hard reset
      @(negedge clk); hrst = 1'b1;
      @(negedge clk); hrst = 1'b0;
      rd(2'd0, v); chk("R4 hard reset clears", v, 32'h0);
      rd(2'd3, v); chk("R10 filter kept", v, 32'h3333);
      rd(2'd1, v); chk("R10 filter kept", v, 32'h1111);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule